// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block watches a processor's activity through two independent 32-bit event counters. Each counter picks one of sixteen event pulse inputs through a 4-bit select held in a shared control word. It adds one on every clock cycle in which that event is high, but only while the processor's current privilege level is enabled in the same control word. Both counters can be read and written together through one 64-bit counter register, so software can preload or snapshot the pair in a single access.

A counter counts as overflowed once its bit 31 is set. To sample every N events, software loads 0x80000000 minus N. The block drives one shared level interrupt while the interrupt enable is set and either counter has its top bit set. Software clears the interrupt by rewriting the counters with bit 31 clear.

The privilege decode is a small named selector with five choices. GATE_EXC is taken whenever the exception-level input is high. Otherwise the mode code picks GATE_KERNEL (code 00), GATE_SUPER (01) or GATE_USER (10). The reserved code 11 selects GATE_NONE. The selector is purely combinational and has no transitions of its own. It is re-evaluated every cycle from the mode inputs.

Top module: `dual_event_counter`

## Requirements
- R1: After reset, the control word and both counters read as zero and `irq` is low.
- R2: A write with `reg_addr`=0 stores `reg_wdata[12:0]` as the control word. A read with `reg_addr`=0 returns the control word in bits 12:0 and zero in bits 63:13.
- R3: A write with `reg_addr`=1 loads counter A from `reg_wdata[31:0]` and counter B from `reg_wdata[63:32]` in the same cycle. A read with `reg_addr`=1 returns counter B in bits 63:32 and counter A in bits 31:0.
- R4: Counter A uses the event input selected by control bits 8:5, and counter B uses the one selected by bits 12:9. On each enabled clock edge at which the selected event is high, the counter rises by exactly one.
- R5: When the exception-level input is low, counting is enabled by control bit 1 for mode code 00, bit 2 for code 01 and bit 3 for code 10. Code 11 never counts.
- R6: When the exception-level input is high, only control bit 0 decides whether counting is enabled. Bits 3:1 are then ignored.
- R7: `irq` equals control bit 4 ANDed with the OR of bit 31 of both counters. It falls once the counters are rewritten with bit 31 clear.
- R8: A counter-register write in the same cycle as a qualifying event loads the written value, and that event is not added.
- R9: Counters wrap from 0xFFFFFFFF to zero and keep counting after bit 31 is set.
- R10: With an all-zero control word, events do not change either counter and the current values are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_lvl | input | 1 | Processor is at exception level |
| priv_mode | input | 2 | Privilege code: 00 kernel, 01 supervisor, 10 user, 11 reserved |
| events | input | 16 | Event pulse inputs, indexed by the 4-bit selects |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control word, 1 the counter pair |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the register chosen by `reg_addr` |
| irq | output | 1 | Shared level overflow interrupt |

## Verification
A corrupted counter appears on the counter readback at the first clock after the bad update. That is because the read port shows the counter registers directly. A wrong privilege or exception-level decode shows up as a missing or extra increment in that same cycle. A bad top-bit value shows up at once as an `irq` mismatch whenever the interrupt enable is set. Comparing both read views and `irq` against a reference model every cycle therefore pins down a fault to the exact edge that caused it.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int EN_EXC   = 0;
    localparam int EN_KERN  = 1;
    localparam int EN_SUPER = 2;
    localparam int EN_USER  = 3;
    localparam int IRQ_EN   = 4;
    localparam int SEL_LSB  = 5;
    localparam int MODE_W   = 4;

    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'b00,
        PRIV_SUPER  = 2'b01,
        PRIV_USER   = 2'b10,
        PRIV_RSVD   = 2'b11
    } priv_e;

    typedef enum logic [2:0] {
        GATE_EXC,
        GATE_KERNEL,
        GATE_SUPER,
        GATE_USER,
        GATE_NONE
    } gate_e;

    localparam logic REG_CTRL = 1'b0;
    localparam logic REG_CNT  = 1'b1;

endpackage

// File: rtl/pcu_ctrl_reg.sv
module pcu_ctrl_reg #(
    parameter int CTRL_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= wr_data;
        end
    end

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctrl == $past(wr_data));

    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));

endmodule

// File: rtl/pcu_mode_gate.sv
module pcu_mode_gate
    import pcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_lvl,
    input  logic [1:0]        priv_mode,
    input  logic [MODE_W-1:0] en_mask,
    output logic              count_ok
);

    gate_e gate;

    always_comb begin
        if (exc_lvl) begin
            gate = GATE_EXC;
        end else begin
            unique case (priv_e'(priv_mode))
                PRIV_KERNEL: gate = GATE_KERNEL;
                PRIV_SUPER:  gate = GATE_SUPER;
                PRIV_USER:   gate = GATE_USER;
                default:     gate = GATE_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (gate)
            GATE_EXC:    count_ok = en_mask[EN_EXC];
            GATE_KERNEL: count_ok = en_mask[EN_KERN];
            GATE_SUPER:  count_ok = en_mask[EN_SUPER];
            GATE_USER:   count_ok = en_mask[EN_USER];
            default:     count_ok = 1'b0;
        endcase
    end

    assert_exc_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_lvl && !en_mask[EN_EXC]) |-> !count_ok);

    assert_rsvd_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_lvl && priv_mode == 2'b11) |-> !count_ok);

endmodule

// File: rtl/pcu_event_counter.sv
module pcu_event_counter #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 4,
    localparam int NUM_EV = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] events,
    input  logic [SEL_W-1:0]  ev_sel,
    input  logic              count_ok,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  value
);

    logic hit;

    always_comb begin
        hit = events[ev_sel] & count_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (hit) begin
            value <= value + CNT_W'(1);
        end
    end

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> value == $past(load_val));

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && hit) |=> value == $past(value) + CNT_W'(1));

    assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && hit && (&value)) |=> value == '0);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !hit) |=> $stable(value));

endmodule

// File: rtl/dual_event_counter.sv
module dual_event_counter
    import pcu_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SEL_W = 4,
    localparam int NUM_CNT = 2,
    localparam int NUM_EV  = 1 << SEL_W,
    localparam int REG_W   = NUM_CNT * CNT_W,
    localparam int CTRL_W  = SEL_LSB + NUM_CNT * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_lvl,
    input  logic [1:0]        priv_mode,
    input  logic [NUM_EV-1:0] events,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);

    logic [CTRL_W-1:0]  ctrl_q;
    logic               count_ok;
    logic               ctrl_wr;
    logic               cnt_wr;
    logic [REG_W-1:0]   cnt_all;
    logic [NUM_CNT-1:0] top_bits;

    always_comb begin
        ctrl_wr = reg_we && (reg_addr == REG_CTRL);
        cnt_wr  = reg_we && (reg_addr == REG_CNT);
    end

    pcu_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wr_data (reg_wdata[CTRL_W-1:0]),
        .ctrl    (ctrl_q)
    );

    pcu_mode_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_lvl   (exc_lvl),
        .priv_mode (priv_mode),
        .en_mask   (ctrl_q[MODE_W-1:0]),
        .count_ok  (count_ok)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        pcu_event_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .events   (events),
            .ev_sel   (ctrl_q[SEL_LSB + i*SEL_W +: SEL_W]),
            .count_ok (count_ok),
            .load     (cnt_wr),
            .load_val (reg_wdata[i*CNT_W +: CNT_W]),
            .value    (cnt_all[i*CNT_W +: CNT_W])
        );
        assign top_bits[i] = cnt_all[i*CNT_W + CNT_W - 1];
    end

    always_comb begin
        if (reg_addr == REG_CNT) begin
            reg_rdata = cnt_all;
        end else begin
            reg_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
        end
    end

    always_comb begin
        irq = ctrl_q[IRQ_EN] & (|top_bits);
    end

    assert_irq_needs_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt_all[CNT_W-1] || cnt_all[REG_W-1]));

    assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[IRQ_EN] |-> !irq);

    assert_zero_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == '0 && !cnt_wr) |=> $stable(cnt_all));

endmodule

// File: tb/dual_event_counter_test.sv
module dual_event_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_lvl = 1'b0;
    logic [1:0]  priv_mode = 2'b00;
    logic [15:0] events = '0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_event_counter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_lvl   (exc_lvl),
        .priv_mode (priv_mode),
        .events    (events),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // behavioural reference model
    logic [12:0] m_ctrl = '0;
    logic [31:0] m_a = '0;
    logic [31:0] m_b = '0;
    bit ok, hit_a, hit_b;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_a = '0; m_b = '0;
        end else begin
            if (exc_lvl) ok = m_ctrl[0];
            else if (priv_mode == 2'd0) ok = m_ctrl[1];
            else if (priv_mode == 2'd1) ok = m_ctrl[2];
            else if (priv_mode == 2'd2) ok = m_ctrl[3];
            else ok = 0;
            hit_a = ok && events[m_ctrl[8:5]];
            hit_b = ok && events[m_ctrl[12:9]];
            if (reg_we && reg_addr) begin
                m_a = reg_wdata[31:0];
                m_b = reg_wdata[63:32];
            end else begin
                if (hit_a) m_a = m_a + 32'd1;
                if (hit_b) m_b = m_b + 32'd1;
            end
            if (reg_we && !reg_addr) m_ctrl = reg_wdata[12:0];
        end
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (reg_addr) check("R3 model counters", reg_rdata, {m_b, m_a});
            else          check("R2 model control", reg_rdata, {51'b0, m_ctrl});
            check("R7 model irq", {63'b0, irq},
                  {63'b0, m_ctrl[4] & (m_a[31] | m_b[31])});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] ev, input int n);
        @(negedge clk);
        events = ev;
        repeat (n) @(negedge clk);
        events = '0;
    endtask

    task automatic rd(input logic a, output logic [63:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    logic [63:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, v); check("R1 control after reset", v, 64'h0);
        rd(1'b1, v); check("R1 counters after reset", v, 64'h0);
        check("R1 irq after reset", {63'b0, irq}, 64'h0);

        // R2 control masking
        wr(1'b0, 64'hFFFF_0000_0000_E0C2);
        rd(1'b0, v); check("R2 control readback", v, 64'h0000_0000_0000_00C2);

        // R3 joint load
        wr(1'b1, 64'h0000_0005_7FFF_FFFE);
        rd(1'b1, v); check("R3 counter pair load", v, 64'h0000_0005_7FFF_FFFE);

        // R4 / R7: A selects event 3, B event 7, kernel, irq enabled
        wr(1'b0, 64'h0E72);
        priv_mode = 2'b00;
        pulse(16'h0008, 2);
        rd(1'b1, v); check("R4 counter A two events", v, 64'h0000_0005_8000_0000);
        check("R7 irq on top bit", {63'b0, irq}, 64'h1);
        pulse(16'h0080, 1);
        rd(1'b1, v); check("R4 counter B only", v, 64'h0000_0006_8000_0000);
        pulse(16'h0088, 1);
        rd(1'b1, v); check("R9 counts past top bit", v, 64'h0000_0007_8000_0001);

        // R5 mode gating
        @(negedge clk); priv_mode = 2'b10;
        pulse(16'h0088, 3);
        rd(1'b1, v); check("R5 user disabled", v, 64'h0000_0007_8000_0001);
        @(negedge clk); priv_mode = 2'b11;
        pulse(16'h0088, 2);
        rd(1'b1, v); check("R5 reserved code", v, 64'h0000_0007_8000_0001);
        wr(1'b0, 64'h0E76);
        @(negedge clk); priv_mode = 2'b01;
        pulse(16'h0008, 1);
        rd(1'b1, v); check("R5 supervisor enabled", v, 64'h0000_0007_8000_0002);

        // R6 exception level precedence
        @(negedge clk); exc_lvl = 1'b1;
        pulse(16'h0008, 2);
        rd(1'b1, v); check("R6 exception blocked", v, 64'h0000_0007_8000_0002);
        wr(1'b0, 64'h0E71);
        @(negedge clk); priv_mode = 2'b10;
        pulse(16'h0008, 1);
        rd(1'b1, v); check("R6 exception counts", v, 64'h0000_0007_8000_0003);
        @(negedge clk); exc_lvl = 1'b0;

        // R8 write beats increment, R7 deassert
        wr(1'b0, 64'h0E72);
        @(negedge clk); priv_mode = 2'b00;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 64'h0000_0010_0000_0020;
        events = 16'h0088;
        @(negedge clk);
        reg_we = 1'b0; events = '0;
        rd(1'b1, v); check("R8 load over event", v, 64'h0000_0010_0000_0020);
        check("R7 irq cleared", {63'b0, irq}, 64'h0);

        // R9 wrap
        wr(1'b1, 64'h7FFF_FFFF_FFFF_FFFF);
        pulse(16'h0088, 1);
        rd(1'b1, v); check("R9 wrap to zero", v, 64'h8000_0000_0000_0000);
        check("R7 irq from counter B", {63'b0, irq}, 64'h1);

        // R10 zero control stops
        wr(1'b0, 64'h0);
        pulse(16'hFFFF, 3);
        rd(1'b1, v); check("R10 held values", v, 64'h8000_0000_0000_0000);
        check("R10 irq low", {63'b0, irq}, 64'h0);

        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule